// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block chooses which of eight interrupt lines to hand to the processor. It takes the vector of pending, unmasked requests, the vector of lines already in service, a 3-bit rotation offset, a nesting enable and a flag that marks the instance as the primary of a cascaded pair. From these it produces a grant flag and the winning line number. Priority is relative to a moving base: the line at position `offset` ranks highest, the next line up ranks second, and so on, wrapping at eight.

A request is granted only when it outranks everything currently in service. On the primary with nesting enabled, the cascade line (line 2) is not counted as in service for this comparison, so a second request arriving through the cascade can nest over the first. A second lookup, used for end-of-interrupt commands, reports the highest-ranked in-service line and the offset that would make that line the lowest-ranked, which is how rotation is done. The grant is also provided one cycle later from a register. Storage of the pending and in-service vectors and the command decode live outside this block.

Top module: `rot_prio_resolver`

## Requirements
- R1: Line (k + offset_i) mod 8 has rank k, rank 0 being the highest; with nothing in service the grant goes to the pending line of lowest rank, and grant_line_o is always a line whose pending bit is set.
- R2: When pend_i is all zeros, grant_vld_o is 0.
- R3: A pending line is granted only if its rank is strictly lower than the rank of the best in-service line; an equal or higher rank gives grant_vld_o = 0, and the granted line is never one counted as in service.
- R4: When nest_en_i = 1 and primary_i = 1, bit 2 of insvc_i is left out of the grant comparison; with either input at 0 bit 2 counts like any other line.
- R5: eoi_vld_o is 1 exactly when insvc_i is non-zero, and eoi_line_o is then the in-service line of lowest rank under the same rotation; nest_en_i and primary_i do not affect it.
- R6: eoi_rot_o equals (eoi_line_o + 1) mod 8, the offset that makes the serviced line rank last.
- R7: grant_vld_q_o and grant_line_q_o hold the values grant_vld_o and grant_line_o had at the previous rising clock edge; a synchronous active-low reset clears both to 0.
- R8: grant_vld_o, grant_line_o, eoi_vld_o, eoi_line_o and eoi_rot_o follow the inputs within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered grant |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 8 | Pending and unmasked requests, one bit per line |
| insvc_i | input | 8 | Lines currently in service |
| offset_i | input | 3 | Rotation base: the line that ranks highest |
| nest_en_i | input | 1 | Nesting enable |
| primary_i | input | 1 | 1 when this instance is the primary of a cascade |
| grant_vld_o | output | 1 | A request wins over the in-service set |
| grant_line_o | output | 3 | Winning line number |
| grant_vld_q_o | output | 1 | grant_vld_o registered |
| grant_line_q_o | output | 3 | grant_line_o registered |
| eoi_vld_o | output | 1 | Some line is in service |
| eoi_line_o | output | 3 | Highest-ranked in-service line |
| eoi_rot_o | output | 3 | Offset that makes eoi_line_o rank last |

## Verification
The bench aims at rank wrap-around: with a non-zero offset, line 7 outranks line 0, and a resolver that ignored the offset or rotated the wrong way would grant line 0 instead. It sets a pending line equal in rank to the in-service line, where a less-or-equal comparison would re-grant a line already being serviced. It sets the cascade line in service with each combination of nesting and primary, where wrong gating would either block a nested cascade request or let a cascade request through on a secondary. A sweep over all eight offsets with random vectors compares every output, including the registered copy one edge later, against a reference ranking loop.

// File: rtl/prio_res_pkg.sv
// Package prio_res_pkg
// Shared defaults and the rank-compare helper for the rotating priority
// resolver. Assumes the line count is a power of two so that rotation is
// plain modular addition on the index width.
package prio_res_pkg;

    localparam int unsigned DEF_LINES    = 8;
    localparam int unsigned DEF_CASCADE  = 2;

    // Strictly-better test on ranks; the value LINES encodes "none".
    function automatic logic rank_beats(input int unsigned cand, input int unsigned held);
        return cand < held;
    endfunction

endpackage

// File: rtl/prio_rank_finder.sv
// Module prio_rank_finder
// Finds the set bit of lowest rank in a vector, where line
// (k + offset) mod LINES has rank k. Purely combinational.
// Outputs rank LINES and any_o = 0 for an empty vector.
// Assumes LINES is a power of two.
module prio_rank_finder #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IW   = $clog2(LINES),
    localparam int unsigned RW   = IW + 1
) (
    input  logic [LINES-1:0] vec_i,
    input  logic [IW-1:0]    offset_i,
    output logic             any_o,
    output logic [RW-1:0]    rank_o,
    output logic [IW-1:0]    line_o
);

    logic [LINES-1:0] rot;

    // Rotate so that bit k of rot holds the line of rank k.
    for (genvar k = 0; k < LINES; k++) begin : g_rot
        logic [IW-1:0] src;
        assign src    = IW'(k) + offset_i;
        assign rot[k] = vec_i[src];
    end

    // Lowest set bit of the rotated vector gives the best rank.
    always_comb begin
        rank_o = RW'(LINES);
        for (int k = LINES - 1; k >= 0; k--) begin
            if (rot[k]) rank_o = RW'(k);
        end
    end

    // Map rank back to a line number and flag a non-empty vector.
    assign line_o = rank_o[IW-1:0] + offset_i;
    assign any_o  = |vec_i;

endmodule

// File: rtl/prio_grant_reg.sv
// Module prio_grant_reg
// One-cycle registered copy of the grant. Synchronous active-low reset
// clears both fields.
module prio_grant_reg #(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_d,
    input  logic [IW-1:0] line_d,
    output logic          vld_q,
    output logic [IW-1:0] line_q
);

    // Capture the combinational grant on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            line_q <= '0;
        end else begin
            vld_q  <= vld_d;
            line_q <= line_d;
        end
    end

endmodule

// File: rtl/rot_prio_resolver.sv
// Module rot_prio_resolver
// Picks the winning interrupt line out of LINES under a rotating priority
// base, granting only requests that strictly outrank the in-service set.
// With nesting enabled on the primary, the cascade line is dropped from
// the in-service comparison. Also reports the best in-service line for
// end-of-interrupt and the offset that would rotate it to last place.
// Assumes pend_i is already masked and LINES is a power of two.
module rot_prio_resolver #(
    parameter int unsigned LINES        = prio_res_pkg::DEF_LINES,
    parameter int unsigned CASCADE_LINE = prio_res_pkg::DEF_CASCADE,
    localparam int unsigned IW          = $clog2(LINES),
    localparam int unsigned RW          = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] insvc_i,
    input  logic [IW-1:0]    offset_i,
    input  logic             nest_en_i,
    input  logic             primary_i,
    output logic             grant_vld_o,
    output logic [IW-1:0]    grant_line_o,
    output logic             grant_vld_q_o,
    output logic [IW-1:0]    grant_line_q_o,
    output logic             eoi_vld_o,
    output logic [IW-1:0]    eoi_line_o,
    output logic [IW-1:0]    eoi_rot_o
);

    localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE_LINE;

    logic [LINES-1:0] insvc_cmp;
    logic             pend_any, cmp_any;
    logic [RW-1:0]    pend_rank, cmp_rank;
    logic [IW-1:0]    pend_line, cmp_line;

    // Drop the cascade line from the comparison set when nesting on the primary.
    always_comb begin
        insvc_cmp = insvc_i;
        if (nest_en_i && primary_i) insvc_cmp = insvc_i & ~CASC_BIT;
    end

    prio_rank_finder #(.LINES(LINES)) u_pend_rank (
        .vec_i(pend_i), .offset_i(offset_i),
        .any_o(pend_any), .rank_o(pend_rank), .line_o(pend_line)
    );

    prio_rank_finder #(.LINES(LINES)) u_cmp_rank (
        .vec_i(insvc_cmp), .offset_i(offset_i),
        .any_o(cmp_any), .rank_o(cmp_rank), .line_o(cmp_line)
    );

    logic [RW-1:0] eoi_rank;

    prio_rank_finder #(.LINES(LINES)) u_eoi_rank (
        .vec_i(insvc_i), .offset_i(offset_i),
        .any_o(eoi_vld_o), .rank_o(eoi_rank), .line_o(eoi_line_o)
    );

    // Grant only a strictly better rank than the held service level.
    always_comb begin
        grant_vld_o  = pend_any &&
                       prio_res_pkg::rank_beats(int'(pend_rank), int'(cmp_rank));
        grant_line_o = pend_line;
    end

    // Offset that puts the serviced line last in the rotation.
    assign eoi_rot_o = eoi_line_o + IW'(1);

    prio_grant_reg #(.IW(IW)) u_grant_reg (
        .clk(clk), .rst_n(rst_n),
        .vld_d(grant_vld_o), .line_d(grant_line_o),
        .vld_q(grant_vld_q_o), .line_q(grant_line_q_o)
    );

    // ---------------- assertions ----------------
    // R1
    grant_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> pend_i[grant_line_o]);

    // R2
    no_pend_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> !grant_vld_o);

    // R3
    grant_not_in_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> !insvc_cmp[grant_line_o]);

    // R5
    eoi_vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_vld_o == (insvc_i != '0));

    // R5
    eoi_line_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_vld_o |-> insvc_i[eoi_line_o]);

    // R4
    nest_drops_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_en_i && primary_i && insvc_i == CASC_BIT && pend_i != '0) |-> grant_vld_o);

    // R7
    grant_q_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |=> grant_vld_q_o);

    // R7
    grant_q_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld_o |=> !grant_vld_q_o);

    // unused rank outputs of the helper instances
    logic unused_ok;
    assign unused_ok = cmp_any ^ (|cmp_line) ^ (|eoi_rank);

endmodule

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pend_i = '0, insvc_i = '0;
    logic [2:0] offset_i = '0;
    logic       nest_en_i = 1'b0, primary_i = 1'b0;
    logic       grant_vld_o, grant_vld_q_o, eoi_vld_o;
    logic [2:0] grant_line_o, grant_line_q_o, eoi_line_o, eoi_rot_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rot_prio_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .insvc_i(insvc_i),
        .offset_i(offset_i), .nest_en_i(nest_en_i), .primary_i(primary_i),
        .grant_vld_o(grant_vld_o), .grant_line_o(grant_line_o),
        .grant_vld_q_o(grant_vld_q_o), .grant_line_q_o(grant_line_q_o),
        .eoi_vld_o(eoi_vld_o), .eoi_line_o(eoi_line_o), .eoi_rot_o(eoi_rot_o)
    );

    // {pend, insvc, off, nest, prim, exp_gv, exp_gl, exp_ev, exp_el}
    localparam logic [28:0] TBL [14] = '{
        {8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0}, // R2 empty
        {8'h90, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0}, // R1
        {8'h90, 8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0}, // R1 rotated
        {8'h01, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0}, // R1 last rank
        {8'h08, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3}, // R3 equal
        {8'h02, 8'h08, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd3}, // R3 better
        {8'h20, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3}, // R3 worse
        {8'h04, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1, 3'd2, 1'b1, 3'd2}, // R4 nested
        {8'h04, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2}, // R4 secondary
        {8'h04, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2}, // R4 nest off
        {8'h10, 8'h06, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 3'd1}, // R4 R5
        {8'h01, 8'h80, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7}, // R3 wrap
        {8'h01, 8'h80, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 3'd7}, // R1 R3
        {8'hFF, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0}  // R1 all
    };

    function automatic int ref_rank(input logic [7:0] v, input logic [2:0] off);
        for (int k = 0; k < 8; k++) if (v[(k + off) % 8]) return k;
        return 8;
    endfunction

    task automatic cmp1(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_out(input logic gv, input logic [2:0] gl,
                             input logic ev, input logic [2:0] el, input string req);
        cmp1(req, "grant_vld", int'(grant_vld_o), int'(gv));
        if (gv) cmp1(req, "grant_line", int'(grant_line_o), int'(gl));
        cmp1("R5", "eoi_vld", int'(eoi_vld_o), int'(ev));
        if (ev) begin
            cmp1("R5", "eoi_line", int'(eoi_line_o), int'(el));
            cmp1("R6", "eoi_rot", int'(eoi_rot_o), int'(3'(el + 3'd1)));
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic       gv, ev, prev_gv;
        logic [2:0] gl, el, prev_gl;
        // reset state, R7
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp1("R7", "reset grant_vld_q", int'(grant_vld_q_o), 0);
        cmp1("R7", "reset grant_line_q", int'(grant_line_q_o), 0);
        rst_n = 1'b1;

        // table walk; R8: values read before any clock edge
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            {pend_i, insvc_i, offset_i, nest_en_i, primary_i, gv, gl, ev, el} = TBL[i];
            #1;
            check_out(gv, gl, ev, el, $sformatf("R8 R1-table row %0d", i));
        end

        // offset sweep with random vectors against the reference ranking
        prev_gv = 1'b0; prev_gl = '0;
        for (int off = 0; off < 8; off++) begin
            for (int n = 0; n < 40; n++) begin
                int pr, ir;
                logic [7:0] cmpv;
                @(negedge clk);
                #1;
                if (n > 0 || off > 0) begin
                    cmp1("R7", "grant_vld_q", int'(grant_vld_q_o), int'(prev_gv));
                    if (prev_gv) cmp1("R7", "grant_line_q", int'(grant_line_q_o), int'(prev_gl));
                end
                pend_i    = 8'($urandom);
                insvc_i   = 8'($urandom) & 8'($urandom);
                if (n % 5 == 0) pend_i = '0;
                offset_i  = 3'(off);
                nest_en_i = 1'($urandom);
                primary_i = 1'($urandom);
                cmpv = insvc_i;
                if (nest_en_i && primary_i) cmpv[2] = 1'b0;
                pr = ref_rank(pend_i, offset_i);
                ir = ref_rank(cmpv, offset_i);
                gv = (pr < ir);
                gl = 3'((pr + off) % 8);
                ev = (insvc_i != 0);
                el = 3'((ref_rank(insvc_i, offset_i) + off) % 8);
                #1;
                check_out(gv, gl, ev, el, "R1 R3 R4 sweep");
                prev_gv = gv; prev_gl = gl;
            end
        end

        // R7: synchronous reset clears a live registered grant
        @(negedge clk);
        pend_i = 8'h01; insvc_i = '0; offset_i = '0;
        @(negedge clk);
        cmp1("R7", "grant_vld_q before reset", int'(grant_vld_q_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        cmp1("R7", "grant_vld_q after reset", int'(grant_vld_q_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule